// File: doc/BRIEF.md
# Selectable Periodic Interrupt Generator

This block turns a free-running oscillator strobe into a periodic event whose rate software picks with a three-bit code. The oscillator strobe first goes through a fixed divider. A chain of stage counters then divides it further and produces seven period strobes. They step down from the fastest rate (256 Hz when the oscillator is 32.768 kHz) by factors of four and then two, to 0.5 Hz. The strobe that the code picks sets a sticky pending flag. Software clears the flag by writing a zero to its bit. While the flag is set and the code is nonzero, a periodic request is raised.

The periodic request goes out together with two requests produced outside the block, a carry request and an alarm request. A build-time parameter decides how they leave the block: on three separate lines, or on one shared line that is the OR of all three. The flag is a two-state machine. `FLAG_IDLE` means nothing is pending. It moves to `FLAG_PENDING` on a selected strobe, and it returns to `FLAG_IDLE` on a clearing write made in a cycle that has no selected strobe.

Top module: `rtc_periodic_irq`

## Requirements
- R1: After reset the control readback is 0x00, the flag is clear, the select code is 0, and every interrupt output is low.
- R2: Code c, with 1 ≤ c ≤ 7, selects a period of FAST_DIV × {1, 4, 16, 64, 128, 256, 512}[c−1] oscillator strobes. Oscillator strobes are counted from 1 after reset, and the selected strobe falls on every strobe whose count is a multiple of that period.
- R3: A selected strobe sets the flag at the next clock edge. The flag then stays set, including through further strobes, until software clears it (`FLAG_IDLE` to `FLAG_PENDING`, and `FLAG_PENDING` held).
- R4: A control write loads bits 6:4 into the select code. Bit 7 = 0 clears the flag and bit 7 = 1 leaves it unchanged. Bits 3:0 are ignored. The readback is {flag, select, 4'b0000}.
- R5: If a selected strobe and a clearing write fall in the same cycle, the flag ends up set.
- R6: Code 0 selects no strobe, so the flag never becomes set while the code is 0. The periodic request is high only while the flag is set and the code is nonzero.
- R7: With SHARED_IRQ = 0, `irq_periodic` carries the periodic request, `irq_carry` follows `carry_req`, `irq_alarm` follows `alarm_req`, and `irq_shared` is held low.
- R8: With SHARED_IRQ = 1, `irq_shared` is the OR of the periodic request, `carry_req` and `alarm_req`, and the three separate lines are held low.
- R9: Changing the select code does not restart the divider chain. The new code's strobes keep the phase they have had since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle strobe at the oscillator rate |
| ctl_wr | input | 1 | Control register write enable |
| ctl_wdata | input | 8 | Control write data: bit 7 flag, bits 6:4 select code |
| ctl_rdata | output | 8 | Control readback |
| carry_req | input | 1 | Carry request from the neighbouring block |
| alarm_req | input | 1 | Alarm request from the neighbouring block |
| irq_shared | output | 1 | Combined interrupt line (shared build) |
| irq_periodic | output | 1 | Periodic interrupt line (split build) |
| irq_carry | output | 1 | Carry interrupt line (split build) |
| irq_alarm | output | 1 | Alarm interrupt line (split build) |

## Verification
The bench drives a gapped oscillator strobe and walks every code, including the slowest period. A divider built with wrong stage ratios, or one that restarts when the code changes, therefore sets the flag in the wrong cycle. Long bursts of clearing writes are aimed at the fast code so that clears land on strobe cycles. A design where the clear wins would lose those events. A design that treats bit 7 = 1 as a set, or that reads bits 3:0, would show up in the readback. The bench also leaves the flag set after the code goes to 0, and it runs a split build and a shared build side by side. A gate that ignores the code, or routing that leaks onto the unused lines, would drive the wrong output.

// File: rtl/rtc_pit_pkg.sv
package rtc_pit_pkg;
    localparam int SEL_W     = 3;
    localparam int NUM_RATES = (1 << SEL_W) - 1;
    localparam int FLAG_BIT  = 7;
    localparam int SEL_LSB   = 4;

    typedef enum logic [0:0] {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

    // division ratio between stage k-1 and stage k (stage 0 is fed by the fixed divider)
    function automatic int stage_ratio(input int k);
        return (k <= 3) ? 4 : 2;
    endfunction
endpackage

// File: rtl/pit_rate_chain.sv
module pit_rate_chain
    import rtc_pit_pkg::*;
#(
    parameter int FAST_DIV = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 osc_tick,
    output logic [NUM_RATES-1:0] rate_stb
);
    localparam int PW = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;

    logic [PW-1:0] pre_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_cnt <= '0;
        else if (osc_tick)
            pre_cnt <= (pre_cnt == PW'(FAST_DIV - 1)) ? '0 : pre_cnt + 1'b1;
    end

    assign rate_stb[0] = osc_tick && (pre_cnt == PW'(FAST_DIV - 1));

    for (genvar k = 1; k < NUM_RATES; k++) begin : g_stage
        localparam int RATIO = stage_ratio(k);
        localparam int CW    = $clog2(RATIO);
        logic [CW-1:0] cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt <= '0;
            else if (rate_stb[k-1])
                cnt <= (cnt == CW'(RATIO - 1)) ? '0 : cnt + 1'b1;
        end

        assign rate_stb[k] = rate_stb[k-1] && (cnt == CW'(RATIO - 1));

        // a slower strobe can only coincide with the next faster one
        assert_stb_nested_R2: assert property (@(posedge clk) disable iff (!rst_n)
            rate_stb[k] |-> rate_stb[k-1]);
    end
endmodule

// File: rtl/pit_flag_fsm.sv
module pit_flag_fsm
    import rtc_pit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_stb,
    input  logic clr_req,
    output logic flag
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= FLAG_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:    if (sel_stb) state_d = FLAG_PENDING;
            FLAG_PENDING: if (clr_req && !sel_stb) state_d = FLAG_IDLE;
            default:      state_d = FLAG_IDLE;
        endcase
    end

    assign flag = (state_q == FLAG_PENDING);

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_stb |=> flag);
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !sel_stb) |=> !flag);
endmodule

// File: rtl/pit_irq_route.sv
module pit_irq_route #(
    parameter bit SHARED_IRQ = 1'b0
) (
    input  logic per_req,
    input  logic carry_req,
    input  logic alarm_req,
    output logic irq_shared,
    output logic irq_periodic,
    output logic irq_carry,
    output logic irq_alarm
);
    if (SHARED_IRQ) begin : g_shared
        assign irq_shared   = per_req | carry_req | alarm_req;
        assign irq_periodic = 1'b0;
        assign irq_carry    = 1'b0;
        assign irq_alarm    = 1'b0;
    end else begin : g_split
        assign irq_shared   = 1'b0;
        assign irq_periodic = per_req;
        assign irq_carry    = carry_req;
        assign irq_alarm    = alarm_req;
    end
endmodule

// File: rtl/rtc_periodic_irq.sv
module rtc_periodic_irq
    import rtc_pit_pkg::*;
#(
    parameter int FAST_DIV   = 128,
    parameter bit SHARED_IRQ = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_rdata,
    input  logic       carry_req,
    input  logic       alarm_req,
    output logic       irq_shared,
    output logic       irq_periodic,
    output logic       irq_carry,
    output logic       irq_alarm
);
    logic [NUM_RATES-1:0] rate_stb;
    logic [SEL_W-1:0]     sel_q;
    logic                 sel_stb;
    logic                 clr_req;
    logic                 flag;
    logic                 per_req;

    pit_rate_chain #(.FAST_DIV(FAST_DIV)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .rate_stb (rate_stb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sel_q <= '0;
        else if (ctl_wr)
            sel_q <= ctl_wdata[SEL_LSB +: SEL_W];
    end

    always_comb begin
        sel_stb = 1'b0;
        for (int i = 0; i < NUM_RATES; i++)
            if (int'(sel_q) == i + 1) sel_stb = rate_stb[i];
    end

    assign clr_req = ctl_wr && !ctl_wdata[FLAG_BIT];

    pit_flag_fsm u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_stb (sel_stb),
        .clr_req (clr_req),
        .flag    (flag)
    );

    assign per_req   = flag && (sel_q != '0);
    assign ctl_rdata = {flag, sel_q, 4'b0000};

    pit_irq_route #(.SHARED_IRQ(SHARED_IRQ)) u_route (
        .per_req      (per_req),
        .carry_req    (carry_req),
        .alarm_req    (alarm_req),
        .irq_shared   (irq_shared),
        .irq_periodic (irq_periodic),
        .irq_carry    (irq_carry),
        .irq_alarm    (irq_alarm)
    );

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == '0 && !flag) |=> !flag);
    assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == '0) |-> !(irq_periodic || (SHARED_IRQ && irq_shared && !carry_req && !alarm_req)));
    assert_lines_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        SHARED_IRQ ? !(irq_periodic || irq_carry || irq_alarm) : !irq_shared);
endmodule

// File: tb/rtc_periodic_irq_tb_top.sv
module rtc_periodic_irq_tb_top;
    localparam int FD = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic       carry_req = 1'b0;
    logic       alarm_req = 1'b0;

    logic [7:0] rd_a, rd_b;
    logic sh_a, per_a, car_a, alm_a;
    logic sh_b, per_b, car_b, alm_b;

    int checks = 0;
    int fails = 0;
    string phase = "R1";
    bit done = 1'b0;
    int cyc = 0;

    always #2 clk = ~clk;

    rtc_periodic_irq #(.FAST_DIV(FD), .SHARED_IRQ(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .ctl_rdata(rd_a), .carry_req(carry_req),
        .alarm_req(alarm_req), .irq_shared(sh_a), .irq_periodic(per_a),
        .irq_carry(car_a), .irq_alarm(alm_a));

    rtc_periodic_irq #(.FAST_DIV(FD), .SHARED_IRQ(1'b1)) dut_sh (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .ctl_rdata(rd_b), .carry_req(carry_req),
        .alarm_req(alarm_req), .irq_shared(sh_b), .irq_periodic(per_b),
        .irq_carry(car_b), .irq_alarm(alm_b));

    typedef struct packed {
        logic       flag;
        logic [2:0] sel;
    } exp_t;

    exp_t exp_q[$];

    // model state, from the requirements
    int         m_ticks = 0;
    logic       m_flag = 1'b0;
    logic [2:0] m_sel = 3'd0;

    function automatic int period_of(input logic [2:0] c);
        int mult[7] = '{1, 4, 16, 64, 128, 256, 512};
        return FD * mult[c - 1];
    endfunction

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // expected-item producer: samples inputs at the edge and pushes the post-edge state
    always @(posedge clk) begin
        if (rst_n) begin
            logic stb;
            stb = 1'b0;
            if (osc_tick) begin
                m_ticks++;
                if (m_sel != 0 && (m_ticks % period_of(m_sel)) == 0) stb = 1'b1;
            end
            if (stb) m_flag = 1'b1;
            else if (ctl_wr && !ctl_wdata[7]) m_flag = 1'b0;
            if (ctl_wr) m_sel = ctl_wdata[6:4];
            exp_q.push_back('{flag: m_flag, sel: m_sel});
        end
    end

    // monitor: pops and compares half a cycle later
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            logic pr;
            e = exp_q.pop_front();
            pr = e.flag && (e.sel != 0);
            check(phase, "readback", rd_a, {e.flag, e.sel, 4'b0000});
            check(phase, "periodic line", per_a, pr);
            check("R7", "split shared low", sh_a, 0);
            check("R7", "split carry", car_a, carry_req);
            check("R7", "split alarm", alm_a, alarm_req);
            check("R8", "shared line", sh_b, pr | carry_req | alarm_req);
            check("R8", "shared separate lines", {per_b, car_b, alm_b}, 0);
            check("R8", "shared readback", rd_b, {e.flag, e.sel, 4'b0000});
        end
    end

    // gapped oscillator strobe, changed just after each edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 osc_tick <= rst_n && ((cyc % 5) != 3);
    end

    task automatic wr(input logic [7:0] d);
        @(posedge clk); #1;
        ctl_wr = 1'b1; ctl_wdata = d;
        @(posedge clk); #1;
        ctl_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    initial begin
        #3000000;
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(4);
        @(negedge clk);
        check("R1", "reset readback", rd_a, 8'h00);
        check("R1", "reset lines", {sh_a, per_a, car_a, alm_a, sh_b, per_b, car_b, alm_b}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        idle(3);
        check("R1", "idle readback", rd_a, 8'h00);

        phase = "R4 ignored bits";
        wr(8'h9F);  idle(5);
        phase = "R2 R3 code1";
        wr(8'h90);  idle(40);
        phase = "R4 clear";
        wr(8'h10);  idle(3);
        phase = "R5 clear vs strobe";
        for (int i = 0; i < 30; i++) begin
            @(posedge clk); #1 ctl_wr = 1'b1; ctl_wdata = 8'h1A;
        end
        @(posedge clk); #1 ctl_wr = 1'b0;
        idle(5);

        for (int c = 2; c <= 7; c++) begin
            phase = $sformatf("R2 R3 R9 code%0d", c);
            wr({1'b0, 3'(c), 4'h0});
            idle(period_of(3'(c)) * 2 + 40);
            wr({1'b0, 3'(c), 4'h0});
            idle(period_of(3'(c)) + 20);
        end

        phase = "R6 code0";
        wr(8'h00);  idle(2000);
        wr(8'h90);
        for (int i = 0; i < 50 && !rd_a[7]; i++) @(negedge clk);
        phase = "R6 flag kept code0";
        wr(8'h80);  idle(20);
        check("R6", "flag held with code 0", rd_a, 8'h80);
        check("R6", "no periodic line", per_a, 0);

        phase = "R7 R8 side requests";
        @(posedge clk); #1 carry_req = 1'b1; idle(4);
        @(posedge clk); #1 alarm_req = 1'b1; carry_req = 1'b0; idle(4);
        @(posedge clk); #1 alarm_req = 1'b0; idle(4);
        wr(8'h00);  idle(4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule